// File: doc/BRIEF.md
# Polled SPI Master with Register Access

This block is an SPI master that software drives through a small 32-bit register port. Software first clears the enable register, then sets the frame control word, the clock divider and a one-hot chip-select pattern. It then sets the enable register. Frames written to the data register enter a transmit FIFO. The shift engine takes them from the FIFO one by one and clocks them out on MOSI, most significant bit first. Each received frame is placed in a receive FIFO, and software reads it from the same data address.

Software learns the state of a transfer by polling the status word and the two FIFO level registers. The chip select of the chosen device goes low for as long as frames are being shifted, including back-to-back frames, and goes high again when the engine has nothing left to send. Clearing the enable register stops the engine and empties both FIFOs. The transmit-threshold register clips values that are too large, so software can find the FIFO depth by writing values and reading them back.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the status word (offset 0x28) reads 0x06 (bit 1 = TX FIFO has room, bit 2 = TX FIFO empty). Both level registers (TX at 0x20, RX at 0x24) read 0. All `ss_n` lines are high and `sclk` is low.
- R2: The control word (offset 0x00: [3:0] frame bits minus one, [5:4] format, bit 6 phase, bit 7 polarity, [9:8] mode) and the divider (offset 0x14) read back what was written while the enable register (offset 0x08, bit 0) was 0. Writes to either register while enabled leave it unchanged.
- R3: A write to the TX threshold register (offset 0x18) of a value below the FIFO depth reads back unchanged. Any larger value reads back as depth minus one.
- R4: While the enable bit is 0, both FIFO levels are 0, and writes to the data register (offset 0x60) are dropped.
- R5: A data write while the TX FIFO holds depth entries is dropped, and status bit 1 then reads 0. A data read while the RX FIFO is empty returns 0.
- R6: In mode 0 (transmit and receive), each frame sent pushes exactly one frame into the RX FIFO. That frame holds the bits sampled from MISO, right-aligned to the frame size (4 to 16 bits). Frames come out in the order they were sent.
- R7: In mode 1 (transmit only), the RX FIFO level stays at 0 after frames are sent.
- R8: In mode 2 (receive only), frames are still clocked out from the TX FIFO. Each frame sent also produces one received frame.
- R9: Bit 0 of the divider is forced to 0. The SCLK period equals the stored divider value in core clocks. With a divider of 0, no frame starts and queued frames stay in the TX FIFO.
- R10: Between frames, `sclk` rests at the polarity bit. With phase 0, MISO is sampled on the first clock edge of each bit. With phase 1, it is sampled on the second edge. Loopback returns the sent data in all four polarity and phase combinations.
- R11: A chip-select line is low only while a transfer is active and its bit is set in the slave-select register (offset 0x10). It stays low across back-to-back frames and goes high once when the engine goes idle.
- R12: Status bit 0 (busy) is 1 from the cycle after the first frame leaves the TX FIFO until the last bit has been shifted. It is 0 when the engine is idle.
- R13: Frames are shifted out MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read at the data address pops the RX FIFO |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that software changes the control word and the divider only while the core is disabled. The hold rule in the register file enforces this. The FIFO checks also assume that a flush is never overlapped by a push, which holds because data writes are gated by the enable bit. The bench therefore always clears the enable register before it reconfigures. It ties MISO to MOSI, so the received value is fully set by what was sent. Its divider values are 0 or at least 2, which keeps every half period at one or more core clocks.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_EN    = 8'h08;
   localparam logic [7:0] OFS_SEL   = 8'h10;
   localparam logic [7:0] OFS_DIV   = 8'h14;
   localparam logic [7:0] OFS_THR   = 8'h18;
   localparam logic [7:0] OFS_TXLVL = 8'h20;
   localparam logic [7:0] OFS_RXLVL = 8'h24;
   localparam logic [7:0] OFS_STAT  = 8'h28;
   localparam logic [7:0] OFS_DATA  = 8'h60;

   typedef enum logic [1:0] {
      XM_DUPLEX = 2'd0,
      XM_SEND   = 2'd1,
      XM_RECV   = 2'd2,
      XM_ROMRD  = 2'd3
   } xfer_mode_e;

   // control word, bit 9 down to bit 0
   typedef struct packed {
      xfer_mode_e  mode;
      logic        cpol;
      logic        cpha;
      logic [1:0]  fmt;
      logic [3:0]  fsz;
   } ctrl_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [WIDTH-1:0]           wdata,
   input  logic                       pop,
   output logic [WIDTH-1:0]           rdata,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW   = $clog2(DEPTH+1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("spi_fifo: DEPTH must lie in 2..256");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
   logic [LW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign level   = cnt;
   assign rdata   = mem[rptr];

   if (POW2) begin : g_wrap_free
      always_comb begin
         wptr_nx = wptr + AW'(1);
         rptr_nx = rptr + AW'(1);
      end
   end else begin : g_wrap_cmp
      always_comb begin
         wptr_nx = (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
         rptr_nx = (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + LW'(1);
            2'b01:   cnt <= cnt - LW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R5
   push_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(level));
   // R4
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));

endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
   parameter int HW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] half,
   output logic          tick
);
   logic [HW-1:0] cnt;

   assign tick = run && (half != '0) && (cnt == half - HW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + HW'(1);
   end

   // R9
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half > HW'(1)) |=> !tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
   import spi_ctl_pkg::*;
#(
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  xfer_mode_e    mode,
   input  logic          cpha,
   input  logic [3:0]    fsz,
   input  logic          half_zero,
   input  logic          tick,
   input  logic          tx_empty,
   input  logic [FW-1:0] tx_head,
   output logic          tx_pop,
   output logic          rx_push,
   output logic [FW-1:0] rx_word,
   input  logic          miso,
   output logic          sclk_i,
   output logic          mosi,
   output logic          busy
);
   localparam int CW = $clog2(FW+1);
   localparam int EW = CW + 1;

   if (FW < 4 || FW > 16) begin : g_bad_fw
      $error("spi_shifter: FW must lie in 4..16");
   end

   typedef enum logic {SH_IDLE, SH_XFER} sh_state_e;
   sh_state_e state;

   logic [CW-1:0] nbits;
   logic [EW-1:0] ecnt, last_idx;
   logic [FW-1:0] txsh, rxsh, rx_next, align;
   logic [FW:0]   mask;
   logic          last_edge, sample_edge, drive_edge;
   logic          frame_done, start, load;

   always_comb begin
      nbits       = (fsz < 4'd3) ? CW'(4) : CW'(fsz) + CW'(1);
      last_idx    = {nbits, 1'b0} - EW'(1);
      last_edge   = (ecnt == last_idx);
      sample_edge = tick && (ecnt[0] == cpha);
      drive_edge  = tick && (ecnt[0] != cpha) && !last_edge;
      rx_next     = sample_edge ? {rxsh[FW-2:0], miso} : rxsh;
      mask        = ({{FW{1'b0}}, 1'b1} << nbits) - {{FW{1'b0}}, 1'b1};
      align       = tx_head << (CW'(FW) - nbits);
      frame_done  = (state == SH_XFER) && tick && last_edge;
      start       = (state == SH_IDLE) && enable && !tx_empty && !half_zero;
      load        = start || (frame_done && enable && !tx_empty);
   end

   assign tx_pop  = load;
   assign rx_push = frame_done && (mode != XM_SEND);
   assign rx_word = rx_next & mask[FW-1:0];
   assign busy    = (state == SH_XFER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SH_IDLE;
         ecnt   <= '0;
         sclk_i <= 1'b0;
         txsh   <= '0;
         rxsh   <= '0;
         mosi   <= 1'b0;
      end else if (!enable) begin
         state  <= SH_IDLE;
         ecnt   <= '0;
         sclk_i <= 1'b0;
      end else if (load) begin
         state  <= SH_XFER;
         ecnt   <= '0;
         sclk_i <= 1'b0;
         rxsh   <= '0;
         if (!cpha) begin
            mosi <= align[FW-1];
            txsh <= align << 1;
         end else begin
            txsh <= align;
         end
      end else if (frame_done) begin
         state  <= SH_IDLE;
         ecnt   <= '0;
         sclk_i <= 1'b0;
      end else if (state == SH_XFER && tick) begin
         ecnt   <= ecnt + EW'(1);
         sclk_i <= ~sclk_i;
         rxsh   <= rx_next;
         if (drive_edge) begin
            mosi <= txsh[FW-1];
            txsh <= txsh << 1;
         end
      end
   end

   // R10
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_IDLE) |-> (sclk_i == 1'b0));
   // R9
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_IDLE && half_zero) |=> (state == SH_IDLE));
   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && enable && !tick) |=> busy);

endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
   import spi_ctl_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int DIV_W      = 16,
   parameter int NUM_SS     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n
);
   localparam int FW  = 16;
   localparam int HW  = DIV_W - 1;
   localparam int LW  = $clog2(FIFO_DEPTH+1);
   localparam int THW = $clog2(FIFO_DEPTH);

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
      $error("spi_master_regs: DIV_W must lie in 2..16");
   end
   if (NUM_SS < 1 || NUM_SS > 16) begin : g_bad_ss
      $error("spi_master_regs: NUM_SS must lie in 1..16");
   end

   logic              en_q;
   ctrl_t             ctrl_q;
   logic [DIV_W-1:0]  div_q;
   logic [NUM_SS-1:0] sel_q;
   logic [THW-1:0]    thr_q;

   logic          tx_push, rx_pop, tx_pop, rx_push;
   logic [FW-1:0] tx_head, rx_head, rx_word;
   logic [LW-1:0] tx_lvl, rx_lvl;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          busy, tick, sclk_i;
   logic [HW-1:0] half;

   assign tx_push = bus_wr && (bus_addr == OFS_DATA) && en_q;
   assign rx_pop  = bus_rd && (bus_addr == OFS_DATA);
   assign half    = div_q[DIV_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ctrl_q <= '0;
         div_q  <= '0;
         sel_q  <= '0;
         thr_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            OFS_EN:  en_q  <= bus_wdata[0];
            OFS_SEL: sel_q <= bus_wdata[NUM_SS-1:0];
            OFS_THR: thr_q <= (bus_wdata >= 32'(FIFO_DEPTH)) ?
                              THW'(FIFO_DEPTH-1) : bus_wdata[THW-1:0];
            OFS_CTRL: if (!en_q) ctrl_q <= ctrl_t'(bus_wdata[9:0]);
            OFS_DIV:  if (!en_q) div_q  <= {bus_wdata[DIV_W-1:1], 1'b0};
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL:  bus_rdata = 32'(ctrl_q);
         OFS_EN:    bus_rdata = 32'(en_q);
         OFS_SEL:   bus_rdata = 32'(sel_q);
         OFS_DIV:   bus_rdata = 32'(div_q);
         OFS_THR:   bus_rdata = 32'(thr_q);
         OFS_TXLVL: bus_rdata = 32'(tx_lvl);
         OFS_RXLVL: bus_rdata = 32'(rx_lvl);
         OFS_STAT:  bus_rdata = {25'd0, 2'b00, rx_full, !rx_empty,
                                 tx_empty, !tx_full, busy};
         OFS_DATA:  bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
         default:   bus_rdata = '0;
      endcase
   end

   spi_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FW)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(!en_q),
      .push(tx_push), .wdata(bus_wdata[FW-1:0]),
      .pop(tx_pop), .rdata(tx_head),
      .level(tx_lvl), .full(tx_full), .empty(tx_empty));

   spi_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(!en_q),
      .push(rx_push), .wdata(rx_word),
      .pop(rx_pop), .rdata(rx_head),
      .level(rx_lvl), .full(rx_full), .empty(rx_empty));

   spi_baud #(.HW(HW)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick));

   spi_shifter #(.FW(FW)) u_shift (
      .clk(clk), .rst_n(rst_n), .enable(en_q),
      .mode(ctrl_q.mode), .cpha(ctrl_q.cpha), .fsz(ctrl_q.fsz),
      .half_zero(half == '0), .tick(tick),
      .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word),
      .miso(miso), .sclk_i(sclk_i), .mosi(mosi), .busy(busy));

   assign sclk = ctrl_q.cpol ^ sclk_i;
   assign ss_n = ~(sel_q & {NUM_SS{busy}});

   // R4
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (tx_lvl == '0 && rx_lvl == '0));
   // R7
   send_only_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode == XM_SEND && !rx_pop) |=> (rx_lvl <= $past(rx_lvl)));
   // R11
   ss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !busy) |-> (&ss_n));
   // R2
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_q) |-> ($stable(ctrl_q) && $stable(div_q)));

endmodule

// File: tb/spi_master_regs_tb.sv
module spi_master_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int NVEC       = 8;

   // {mode[1:0], cpol, cpha, fsz-1[3:0], div[7:0], data[15:0]}
   localparam logic [31:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 1'b0, 4'd7,  8'd4, 16'h00A5},
      {2'd0, 1'b0, 1'b1, 4'd7,  8'd6, 16'h003C},
      {2'd0, 1'b1, 1'b0, 4'd15, 8'd2, 16'hBEEF},
      {2'd0, 1'b1, 1'b1, 4'd3,  8'd8, 16'h00FB},
      {2'd2, 1'b0, 1'b0, 4'd11, 8'd4, 16'h0ABC},
      {2'd1, 1'b0, 1'b0, 4'd7,  8'd4, 16'h0055},
      {2'd0, 1'b1, 1'b1, 4'd9,  8'd5, 16'h02C3},
      {2'd0, 1'b0, 1'b0, 4'd15, 8'd2, 16'h8001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sclk, mosi, miso;
   logic [3:0]  ss_n;

   int checks = 0;
   int fails  = 0;

   assign miso = mosi;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_master_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

   // serial monitor for the directed ordering test (phase 0, polarity 0)
   logic        mon_en = 1'b0;
   logic [23:0] mon_word = '0;
   int          mon_cnt = 0;
   int          ss_rise = 0;
   longint      t_last = 0, t_prev = 0;

   always @(posedge sclk) begin
      if (mon_en && !ss_n[0]) begin
         mon_word = {mon_word[22:0], mosi};
         mon_cnt  = mon_cnt + 1;
         t_prev   = t_last;
         t_last   = $time;
      end
   end
   always @(posedge ss_n[0]) begin
      if (mon_en) ss_rise = ss_rise + 1;
   end

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails = fails + 1;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      report();
   end

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #(CLK_PERIOD/4);
      d = bus_rdata;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] st;
      for (int n = 0; n < 4000; n++) begin
         rd(8'h28, st);
         if (st[0] == 1'b0 && st[2] == 1'b1) break;
      end
   endtask

   initial begin
      logic [31:0] v, exp, ctrl;
      logic [3:0]  sel;
      int          nb;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h28, v); chk(v == 32'h6, "R1 status", v, 32'h6);
      rd(8'h20, v); chk(v == 0, "R1 tx level", v, 0);
      rd(8'h24, v); chk(v == 0, "R1 rx level", v, 0);
      chk(ss_n == 4'hF, "R1 ss_n", 32'(ss_n), 32'hF);
      chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);

      // table of loopback vectors
      for (int i = 0; i < NVEC; i++) begin
         nb   = int'(VEC[i][27:24]) + 1;
         ctrl = {22'd0, VEC[i][31:30], VEC[i][29], VEC[i][28], 2'b00, VEC[i][27:24]};
         sel  = 4'(1 << (i % 4));
         wr(8'h08, 0);
         wr(8'h00, ctrl);
         wr(8'h14, {24'd0, VEC[i][23:16]});
         wr(8'h10, {28'd0, sel});
         wr(8'h08, 1);
         chk(sclk == VEC[i][29], "R10 idle polarity", 32'(sclk), 32'(VEC[i][29]));
         wr(8'h60, {16'd0, VEC[i][15:0]});
         @(negedge clk);
         chk(ss_n == ~sel, "R11 select during frame", 32'(ss_n), 32'(~sel));
         wait_idle();
         chk(ss_n == 4'hF, "R11 select released", 32'(ss_n), 32'hF);
         rd(8'h24, v);
         if (VEC[i][31:30] == 2'd1) begin
            chk(v == 0, "R7 send-only rx level", v, 0);
         end else begin
            exp = {16'd0, VEC[i][15:0]} & ((32'd1 << nb) - 1);
            chk(v == 1, "R6 R8 one rx frame per tx frame", v, 1);
            rd(8'h60, v);
            chk(v == exp, "R6 R8 R10 loopback data", v, exp);
         end
      end

      // R2 control and divider hold while enabled
      wr(8'h08, 0);
      wr(8'h00, 32'h0007);
      wr(8'h14, 32'd7);
      rd(8'h00, v); chk(v == 32'h7, "R2 control readback", v, 32'h7);
      rd(8'h14, v); chk(v == 32'd6, "R9 divider bit0 cleared", v, 6);
      wr(8'h08, 1);
      wr(8'h00, 32'h03FF);
      wr(8'h14, 32'd20);
      rd(8'h00, v); chk(v == 32'h7, "R2 control held while enabled", v, 32'h7);
      rd(8'h14, v); chk(v == 32'd6, "R2 divider held while enabled", v, 6);

      // R3 threshold clipping
      wr(8'h18, 3);
      rd(8'h18, v); chk(v == 3, "R3 threshold in range", v, 3);
      wr(8'h18, DEPTH);
      rd(8'h18, v); chk(v == DEPTH-1, "R3 threshold at depth", v, DEPTH-1);
      wr(8'h18, 1000);
      rd(8'h18, v); chk(v == DEPTH-1, "R3 threshold large", v, DEPTH-1);

      // R9 divider zero stalls; R5 full drop
      wr(8'h08, 0);
      wr(8'h14, 0);
      wr(8'h10, 1);
      wr(8'h08, 1);
      for (int k = 0; k < DEPTH + 2; k++) wr(8'h60, 32'(k));
      repeat (40) @(negedge clk);
      rd(8'h20, v); chk(v == DEPTH, "R5 R9 tx level stays full", v, DEPTH);
      rd(8'h28, v); chk(v[1] == 1'b0, "R5 not-full bit low", 32'(v[1]), 0);
      chk(v[0] == 1'b0, "R9 no frame with divider 0", 32'(v[0]), 0);
      chk(ss_n == 4'hF, "R11 no select when stalled", 32'(ss_n), 32'hF);

      // R4 disable flushes; data writes dropped while disabled
      wr(8'h08, 0);
      rd(8'h20, v); chk(v == 0, "R4 tx flushed", v, 0);
      wr(8'h60, 32'h5A);
      rd(8'h20, v); chk(v == 0, "R4 write dropped while disabled", v, 0);

      // R13 R6 R11 R9 R12 back-to-back frames, MSB first, ordering
      wr(8'h00, 32'h0007);
      wr(8'h14, 4);
      wr(8'h10, 1);
      mon_en   = 1'b1;
      mon_cnt  = 0;
      ss_rise  = 0;
      mon_word = '0;
      wr(8'h08, 1);
      wr(8'h60, 32'h81);
      wr(8'h60, 32'h42);
      wr(8'h60, 32'h17);
      rd(8'h28, v); chk(v[0] == 1'b1, "R12 busy while shifting", 32'(v[0]), 1);
      wait_idle();
      mon_en = 1'b0;
      rd(8'h28, v); chk(v[0] == 1'b0, "R12 busy clear when idle", 32'(v[0]), 0);
      chk(mon_cnt == 24, "R13 bit count", 32'(mon_cnt), 24);
      chk(mon_word == 24'h814217, "R13 MSB-first bit stream", 32'(mon_word), 32'h814217);
      chk(ss_rise == 1, "R11 select held across frames", 32'(ss_rise), 1);
      chk((t_last - t_prev) == 4*CLK_PERIOD, "R9 sclk period",
          32'(t_last - t_prev), 32'(4*CLK_PERIOD));
      rd(8'h24, v); chk(v == 3, "R6 rx level after three frames", v, 3);
      rd(8'h60, v); chk(v == 32'h81, "R6 first frame", v, 32'h81);
      rd(8'h60, v); chk(v == 32'h42, "R6 second frame", v, 32'h42);
      rd(8'h60, v); chk(v == 32'h17, "R6 third frame", v, 32'h17);
      rd(8'h60, v); chk(v == 0, "R5 empty read returns 0", v, 0);

      report();
   end
endmodule